// File: doc/BRIEF.md
# Smart-Card Half-Duplex UART with Parity Error Signalling

This block moves character frames over a single shared, pulled-up serial line of the kind a smart card uses. It sends and receives frames made of a start bit, eight data bits sent least significant bit first, an even-parity bit and a stop bit. Bit timing comes from a supplied tick enable: every bit lasts a fixed number of ticks, and the receiver samples each bit once, in the middle of its bit period. The transmit output is open drain. The port `tx_pull` set to 1 means the pin drives low. When it is 0 the pin floats, and the external pull-up holds the line high.

When a received frame fails its parity check and signalling is enabled, the block pulls the line low from the start of the stop-bit slot. This tells the sender that the character was bad. The pull holds until software reads the receive buffer. That read also clears the error flag. The received byte is stored even when its parity is wrong. The block does not start a new transmit frame while the error pull is held.

For frames it sends, the block stores the line level seen in the middle of its own stop bit. This shows whether the card answered with an error signal. The stored value can be read when the transmit-finished pulse fires.

Top module: `sc_uart`

## Requirements
- R1: A transmitted frame is a low start bit, then data bits D0 to D7 with D0 first, then a bit that makes the count of ones across data and parity even, then a high stop bit. Each bit lasts OVS ticks. While the receiver is busy, no frame is sent, and the receiver ignores the line while a frame is being sent.
- R2: A low line seen on a tick while idle starts reception, and each bit is sampled at tick MID (OVS/2) of its period. At the start of the stop-bit slot, `rx_data` takes the received byte with D0 in bit 0 and `rx_ready` goes to 1. This happens even when the parity is wrong.
- R3: At that same point, `par_err` goes to 1 if the received data and parity bits together hold an odd number of ones, and to 0 otherwise.
- R4: With `err_en` at 1, a parity failure sets `tx_pull` to 1 from the start of the stop-bit slot. It stays at 1 for as long as no read occurs.
- R5: With `err_en` at 0, a parity failure sets `par_err` but leaves `tx_pull` at 0.
- R6: A one-cycle `rx_rd` clears `par_err` and `rx_ready` and releases `tx_pull`, all at the same clock edge.
- R7: A `tx_load` given while the error pull is held does not start a frame. The frame starts on the first tick after the read releases the line.
- R8: `tx_done` is a one-cycle pulse raised at the tick that ends the stop bit, 11·OVS ticks after the start tick of the frame.
- R9: `tx_nak` holds the inverse of the line level sampled at tick MID of the block's own transmitted stop bit, so 1 means the card pulled the line low.
- R10: After reset, `tx_pull`, `rx_ready`, `par_err`, `tx_done` and `tx_nak` are all 0.
- R11: A low pulse that has ended by tick MID of the start bit is dropped: no data is stored and `rx_ready` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | Transfer-clock enable; OVS ticks make one bit |
| rx_in | input | 1 | Level of the shared line |
| err_en | input | 1 | 1 enables driving the error signal on parity failure |
| rx_rd | input | 1 | Receive-buffer read strobe |
| tx_data | input | 8 | Byte to transmit |
| tx_load | input | 1 | Loads `tx_data` as a pending transmit request |
| tx_pull | output | 1 | Open-drain drive: 1 pulls the line low, 0 releases it |
| rx_data | output | 8 | Receive buffer |
| rx_ready | output | 1 | Receive buffer holds an unread byte |
| par_err | output | 1 | Parity error flag for the buffered byte |
| tx_done | output | 1 | One-cycle transmit-finished pulse |
| tx_nak | output | 1 | Line was low during the block's own stop bit |

## Verification
The embedded assertions check, on every cycle, the rules that hold at all times. An error pull needs a set error flag and must have been enabled. A read always releases the pull and clears the flags. No frame starts while the pull is held. The transmitter and receiver are never active together. The completion pulse lasts one cycle and ends a frame. The bench scenarios are what show the data path. They sweep every byte value through both directions. They compare the decoded line bits with parity computed in the bench, check the exact tick of the completion pulse, check the error-signal response returned by the card model, and check that a short low glitch is dropped.

// File: rtl/sc_uart.sv
module sc_uart #(
  parameter int OVS = 4,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_tick,
  input  logic          rx_in,
  input  logic          err_en,
  input  logic          rx_rd,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_load,
  output logic          tx_pull,
  output logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          par_err,
  output logic          tx_done,
  output logic          tx_nak
);
  localparam int NB = DW + 3;
  localparam int CW = (OVS > 2) ? $clog2(OVS) : 2;
  localparam int BW = $clog2(NB + 1);
  localparam logic [CW-1:0] MID  = CW'(OVS / 2);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [BW-1:0] PBIT = BW'(DW + 1);
  localparam logic [BW-1:0] SBIT = BW'(NB - 1);

  logic          rx_act, rpar, err_hold;
  logic [CW-1:0] rc;
  logic [BW-1:0] rb;
  logic [DW-1:0] rsh;
  logic          tx_act, pend;
  logic [CW-1:0] tc;
  logic [BW-1:0] tb;
  logic [NB-1:0] tsh;
  logic [DW-1:0] tbuf;
  logic          wr, start;

  assign wr    = bit_tick && rx_act && rc == LAST && rb == PBIT;
  assign start = bit_tick && !tx_act && pend && !err_hold && !rx_act;
  assign tx_pull = (tx_act && !tsh[0]) || err_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_act <= 1'b0;
      rc     <= '0;
      rb     <= '0;
      rsh    <= '0;
      rpar   <= 1'b0;
    end else if (bit_tick) begin
      if (!rx_act) begin
        if (!rx_in && !tx_act && !err_hold) begin
          rx_act <= 1'b1;
          rc     <= '0;
          rb     <= '0;
        end
      end else begin
        if (rc == MID) begin
          if (rb == '0 && rx_in) rx_act <= 1'b0;
          else if (rb >= BW'(1) && rb <= BW'(DW)) rsh <= {rx_in, rsh[DW-1:1]};
          else if (rb == PBIT) rpar <= rx_in;
        end
        if (rc == LAST) begin
          rc <= '0;
          if (rb == SBIT) rx_act <= 1'b0;
          else rb <= rb + 1'b1;
        end else begin
          rc <= rc + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_ready <= 1'b0;
      par_err  <= 1'b0;
      err_hold <= 1'b0;
    end else if (wr) begin
      rx_data  <= rsh;
      rx_ready <= 1'b1;
      par_err  <= ^{rsh, rpar};
      err_hold <= (^{rsh, rpar}) && err_en;
    end else if (rx_rd) begin
      rx_ready <= 1'b0;
      par_err  <= 1'b0;
      err_hold <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_act  <= 1'b0;
      pend    <= 1'b0;
      tbuf    <= '0;
      tc      <= '0;
      tb      <= '0;
      tsh     <= '1;
      tx_done <= 1'b0;
      tx_nak  <= 1'b0;
    end else begin
      tx_done <= 1'b0;
      if (start) begin
        tx_act <= 1'b1;
        pend   <= 1'b0;
        tsh    <= {1'b1, ^tbuf, tbuf, 1'b0};
        tc     <= '0;
        tb     <= '0;
      end else if (bit_tick && tx_act) begin
        if (tc == MID && tb == SBIT) tx_nak <= !rx_in;
        if (tc == LAST) begin
          tc  <= '0;
          tsh <= {1'b1, tsh[NB-1:1]};
          if (tb == SBIT) begin
            tx_act  <= 1'b0;
            tx_done <= 1'b1;
          end else begin
            tb <= tb + 1'b1;
          end
        end else begin
          tc <= tc + 1'b1;
        end
      end
      if (tx_load) begin
        pend <= 1'b1;
        tbuf <= tx_data;
      end
    end
  end

  a_r1_half_duplex: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_act && rx_act));
  a_r4_pull_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pull && !tx_act) |-> par_err);
  a_r4_held_until_read: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pull && !tx_act && !rx_rd) |=> tx_pull);
  a_r5_signal_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_hold) |-> $past(err_en));
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && !wr) |=> (!par_err && !rx_ready && !err_hold));
  a_r7_no_start_held: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_act) |-> !$past(err_hold));
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);
  a_r8_done_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (!tx_act && $fell(tx_act)));
endmodule

// File: tb/sc_uart_test.sv
`timescale 1ns/1ps
module sc_uart_test;
  localparam int OVS = 4;
  localparam int MID = OVS / 2;

  logic clk = 1'b0, rst_n = 1'b0, bit_tick = 1'b0;
  logic err_en = 1'b0, rx_rd = 1'b0, tx_load = 1'b0, card_pull = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic tx_pull, rx_ready, par_err, tx_done, tx_nak, line;
  logic [7:0] rx_data;
  logic [1:0] tdiv = 2'd0;
  int n_chk = 0, n_bad = 0;

  assign line = ~(tx_pull | card_pull);

  sc_uart #(.OVS(OVS), .DW(8)) uut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_in(line),
    .err_en(err_en), .rx_rd(rx_rd), .tx_data(tx_data), .tx_load(tx_load),
    .tx_pull(tx_pull), .rx_data(rx_data), .rx_ready(rx_ready),
    .par_err(par_err), .tx_done(tx_done), .tx_nak(tx_nak));

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    tdiv     <= (tdiv == 2'd2) ? 2'd0 : tdiv + 2'd1;
    bit_tick <= (tdiv == 2'd0);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick_wait(input int n);
    repeat (n) begin
      @(posedge clk);
      while (!bit_tick) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic card_frame(input logic [7:0] d, input bit bad);
    logic [10:0] f;
    f = {1'b1, (^d) ^ bad, d, 1'b0};
    for (int i = 0; i < 11; i++) begin
      card_pull = !f[i];
      tick_wait(OVS);
    end
    card_pull = 1'b0;
  endtask

  task automatic read_buf();
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic capture(input logic [7:0] d, input bit nak);
    logic [10:0] fr;
    bit pre, post;
    int guard;
    fr = '1; pre = 1'b0; post = 1'b0; guard = 0;
    tick_wait(1);
    while (line && guard < 200) begin tick_wait(1); guard++; end
    chk(!line, "R1 start", line, 0);
    for (int k = 1; k <= 11 * OVS; k++) begin
      tick_wait(1);
      if (k % OVS == MID) fr[k / OVS] = line;
      if (k == 10 * OVS && nak) card_pull = 1'b1;
      if (k == 11 * OVS - 1) pre = tx_done;
      if (k == 11 * OVS) begin post = tx_done; card_pull = 1'b0; end
    end
    chk(fr[0] == 1'b0, "R1 start bit", fr[0], 0);
    chk(fr[8:1] == d, "R1 data", fr[8:1], d);
    chk(fr[9] == ^d, "R1 parity", fr[9], ^d);
    if (!nak) chk(fr[10] == 1'b1, "R1 stop", fr[10], 1);
    chk(!pre && post, "R8 done timing", {pre, post}, 1);
    chk(tx_nak == nak, "R9 nak flag", tx_nak, nak);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!tx_pull && !rx_ready && !par_err && !tx_done && !tx_nak, "R10 reset",
        {tx_pull, rx_ready, par_err, tx_done, tx_nak}, 0);
    rst_n = 1'b1;
    tick_wait(3);
    chk(!tx_pull && !rx_ready, "R10 idle", {tx_pull, rx_ready}, 0);

    card_pull = 1'b1;
    tick_wait(1);
    card_pull = 1'b0;
    tick_wait(15);
    chk(!rx_ready && !tx_pull, "R11 glitch", {rx_ready, tx_pull}, 0);

    for (int b = 0; b < 256; b++) begin
      bit bad, en;
      bad = (b % 5 == 2);
      en  = b[3];
      err_en = en;
      card_frame(8'(b), bad);
      tick_wait(2);
      chk(rx_ready, "R2 ready", rx_ready, 1);
      chk(rx_data == 8'(b), "R2 data", rx_data, b);
      chk(par_err == bad, "R3 parity flag", par_err, bad);
      if (en) chk(tx_pull == bad, "R4 error pull", tx_pull, bad);
      else    chk(tx_pull == 1'b0, "R5 no pull disabled", tx_pull, 0);
      read_buf();
      chk(!par_err && !rx_ready && !tx_pull, "R6 read clears",
          {par_err, rx_ready, tx_pull}, 0);
      tick_wait(2);
    end

    err_en = 1'b1;
    card_frame(8'h5A, 1'b1);
    tick_wait(2);
    tx_data = 8'hC3; tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
    begin
      int held;
      held = 0;
      for (int i = 0; i < 40; i++) begin
        tick_wait(1);
        if (tx_pull && !tx_done) held++;
      end
      chk(held == 40, "R7 no start while held", held, 40);
      chk(rx_data == 8'h5A && par_err, "R4 held data kept", rx_data, 8'h5A);
    end
    read_buf();
    chk(line == 1'b1, "R6 line released", line, 1);
    capture(8'hC3, 1'b0);
    tick_wait(2);

    for (int b = 0; b < 256; b++) begin
      bit nak;
      nak = (b % 3 == 1);
      tx_data = 8'(b); tx_load = 1'b1;
      @(negedge clk);
      tx_load = 1'b0;
      capture(8'(b), nak);
      tick_wait(2);
      chk(!rx_ready, "R1 rx ignores own frame", rx_ready, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule